// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This block moves a plain word stream into system memory. It drives the write side of an AXI4 master: the address, write-data and write-response channels. Every burst is an incrementing burst of a fixed length. A small register-style command port starts a transfer. The host writes three words in order: a select word, a byte start address and a word count. The block then issues one address burst for each group of `BURST_LEN` words. It sends the matching data beats and holds `busy` high until every write response for the job has come back.

On the stream side, `s_ready` is a request to stop, not a per-beat handshake. A word is taken on every cycle that `s_valid` is high, whatever the level of `s_ready`. An internal buffer absorbs the words that upstream is still sending when it notices the stop request. The block assumes an error-free, in-order memory system. Both transaction IDs are tied to zero, so each data beat carries the same ID as its address burst, and the response code is never examined.

Top module: `strm_burst_wr`

## Requirements
- R1: A transfer starts only after three writes on the command port while idle. First comes a write with `cfg_sel`=1. Next comes a write with `cfg_sel`=0, which carries the byte start address. Last comes a write with `cfg_sel`=0, which carries the word count in its low `CNT_W` bits. While idle, writes with `cfg_sel`=0 are ignored. A write with `cfg_sel`=1 in the middle of the sequence restarts it at the address step.
- R2: A count of zero starts nothing: `busy` stays 0 and no address or data beat is issued.
- R3: Command writes made while `busy` is 1 have no effect. No second transfer is started by them.
- R4: A count of N words gives exactly ceil(N/`BURST_LEN`) address bursts. The first burst uses the programmed address, and each later burst adds `BURST_LEN`×(`DATA_W`/8) bytes. Every burst has `m_awlen`=`BURST_LEN`-1, `m_awsize`=log2(`DATA_W`/8) and `m_awburst`=2'b01 (incrementing).
- R5: `m_awid` and `m_wid` are zero on every handshake.
- R6: Data beats carry the stream words in arrival order, with `m_wstrb` all ones. `m_wlast` is 1 exactly on every `BURST_LEN`-th beat of the transfer.
- R7: When N is not a multiple of `BURST_LEN`, the last burst is filled out with beats whose data is zero.
- R8: A word is stored on every cycle that `s_valid` is 1. `s_ready` is 0 exactly when the free buffer space is at most `STOP_MARGIN`. An upstream that stops within `STOP_MARGIN` cycles loses no word.
- R9: `m_bready` is held at 1. `busy` goes to 1 after the count write and returns to 0 in the cycle after the write-response handshake that completes the transfer. The response code is not examined.
- R10: After reset `busy`, `m_awvalid` and `m_wvalid` are 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Command write strobe |
| cfg_sel | input | 1 | Marks a command write as the select word |
| cfg_data | input | ADDR_W | Command write data (address or count) |
| busy | output | 1 | Transfer in progress |
| s_valid | input | 1 | Stream word present |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Low requests upstream to stop |
| m_awid | output | ID_W | Write address ID (zero) |
| m_awaddr | output | ADDR_W | Burst start byte address |
| m_awlen | output | 8 | Beats per burst minus one |
| m_awsize | output | 3 | Bytes per beat, log2 encoded |
| m_awburst | output | 2 | Burst type (incrementing) |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address accepted |
| m_wid | output | ID_W | Write data ID (zero) |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes (all ones) |
| m_wlast | output | 1 | Final beat of a burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready (always 1) |

## Verification
A burst counter that is off by one shows up at once as a wrong beat count or as a misplaced `m_wlast`. A bad address step appears on the second address handshake of any job that spans more than one burst. A corrupt buffer level either drops or repeats a word, which the beat-by-beat data compare catches within the same transfer. A stall phase on the write channel fills the buffer and proves that `s_ready` falls in time. A response counter that is wrong leaves `busy` high too long or drops it too early, and the level of `busy` is checked at every response.

// File: rtl/strm_wr_pkg.sv
package strm_wr_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_ADDR = 2'd1,
        CFG_CNT  = 2'd2
    } cfg_state_e;

    localparam logic [1:0] AXI_BURST_INCR = 2'b01;

endpackage

// File: rtl/strm_wr_fifo.sv
module strm_wr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     push_data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [LVL_W-1:0] free_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push_i) d.wp = q.wp + PTR_W'(1);
        if (pop_i)  d.rp = q.rp + PTR_W'(1);
        if (push_i && !pop_i)      d.lvl = q.lvl + LVL_W'(1);
        else if (pop_i && !push_i) d.lvl = q.lvl - LVL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[q.wp] <= push_data_i;
    end

    assign head_o  = mem[q.rp];
    assign empty_o = (q.lvl == '0);
    assign full_o  = (q.lvl == LVL_W'(DEPTH));
    assign free_o  = LVL_W'(DEPTH) - q.lvl;

endmodule

// File: rtl/strm_wr_cfg.sv
module strm_wr_cfg
    import strm_wr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              cfg_sel_i,
    input  logic [ADDR_W-1:0] cfg_data_i,
    input  logic              busy_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [CNT_W-1:0]  start_cnt_o
);

    typedef struct packed {
        cfg_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              start;
    } cfg_t;

    cfg_t q, d;
    logic [CNT_W-1:0] wr_cnt;

    assign wr_cnt = cfg_data_i[CNT_W-1:0];

    always_comb begin
        d       = q;
        d.start = 1'b0;
        case (q.st)
            CFG_IDLE: begin
                // a pending start counts as busy so no second job slips in
                if (cfg_wr_i && cfg_sel_i && !busy_i && !q.start) d.st = CFG_ADDR;
            end
            CFG_ADDR: begin
                if (cfg_wr_i) begin
                    if (cfg_sel_i) begin
                        d.st = CFG_ADDR;
                    end else begin
                        d.addr = cfg_data_i;
                        d.st   = CFG_CNT;
                    end
                end
            end
            CFG_CNT: begin
                if (cfg_wr_i) begin
                    if (cfg_sel_i) begin
                        d.st = CFG_ADDR;
                    end else begin
                        d.cnt   = wr_cnt;
                        d.start = (wr_cnt != '0);
                        d.st    = CFG_IDLE;
                    end
                end
            end
            default: d.st = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o      = q.start;
    assign start_addr_o = q.addr;
    assign start_cnt_o  = q.cnt;

endmodule

// File: rtl/strm_wr_engine.sv
module strm_wr_engine #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 4,
    localparam int LOG_BL = $clog2(BURST_LEN),
    localparam int BEAT_W = CNT_W + 1,
    localparam int STEP   = BURST_LEN * (DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  start_cnt_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_head_i,
    output logic              fifo_pop_o,
    output logic              awvalid_o,
    input  logic              awready_i,
    output logic [ADDR_W-1:0] awaddr_o,
    output logic              wvalid_o,
    input  logic              wready_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wlast_o,
    input  logic              bvalid_i,
    output logic              busy_o
);

    typedef struct packed {
        logic              busy;
        logic              awvalid;
        logic [ADDR_W-1:0] awaddr;
        logic [BEAT_W-1:0] aw_left;
        logic [BEAT_W-1:0] b_left;
        logic [BEAT_W-1:0] beat_idx;
        logic [BEAT_W-1:0] beat_total;
        logic [CNT_W-1:0]  words;
    } eng_t;

    eng_t q, d;
    logic [BEAT_W-1:0] nb_start;
    logic pad, aw_hs, w_hs, b_hs;

    always_comb begin
        // bursts needed, rounded up to whole bursts
        nb_start   = ({1'b0, start_cnt_i} + BEAT_W'(BURST_LEN - 1)) >> LOG_BL;
        pad        = (q.beat_idx >= {1'b0, q.words});
        wvalid_o   = q.busy && (q.beat_idx != q.beat_total) && (pad || !fifo_empty_i);
        wlast_o    = &q.beat_idx[LOG_BL-1:0];
        wdata_o    = pad ? '0 : fifo_head_i;
        aw_hs      = q.awvalid && awready_i;
        w_hs       = wvalid_o && wready_i;
        b_hs       = q.busy && bvalid_i;
        fifo_pop_o = w_hs && !pad;

        d = q;
        if (aw_hs) begin
            d.aw_left = q.aw_left - BEAT_W'(1);
            d.awaddr  = q.awaddr + ADDR_W'(STEP);
            d.awvalid = (q.aw_left != BEAT_W'(1));
        end
        if (w_hs) d.beat_idx = q.beat_idx + BEAT_W'(1);
        if (b_hs) begin
            d.b_left = q.b_left - BEAT_W'(1);
            if (q.b_left == BEAT_W'(1)) d.busy = 1'b0;
        end
        if (start_i && !q.busy) begin
            d.busy       = 1'b1;
            d.awvalid    = 1'b1;
            d.awaddr     = start_addr_i;
            d.aw_left    = nb_start;
            d.b_left     = nb_start;
            d.beat_idx   = '0;
            d.beat_total = nb_start << LOG_BL;
            d.words      = start_cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign awvalid_o = q.awvalid;
    assign awaddr_o  = q.awaddr;
    assign busy_o    = q.busy;

endmodule

// File: rtl/strm_burst_wr.sv
module strm_burst_wr
    import strm_wr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int ID_W        = 4,
    parameter int BURST_LEN   = 4,
    parameter int FIFO_DEPTH  = 16,
    parameter int STOP_MARGIN = 4,
    localparam int STRB_W    = DATA_W / 8,
    localparam int SIZE_CODE = $clog2(STRB_W),
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic              busy,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [ID_W-1:0]   m_awid,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ID_W-1:0]   m_wid,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic              m_bvalid,
    output logic              m_bready
);

    logic              job_start;
    logic [ADDR_W-1:0] job_addr;
    logic [CNT_W-1:0]  job_cnt;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [DATA_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_free;

    strm_wr_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
        .busy_i(busy),
        .start_o(job_start), .start_addr_o(job_addr), .start_cnt_o(job_cnt)
    );

    assign fifo_push = s_valid && !fifo_full;

    strm_wr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(fifo_push), .push_data_i(s_data), .pop_i(fifo_pop),
        .head_o(fifo_head), .empty_o(fifo_empty), .full_o(fifo_full),
        .free_o(fifo_free)
    );

    assign s_ready = (fifo_free > LVL_W'(STOP_MARGIN));

    strm_wr_engine #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_i(job_start), .start_addr_i(job_addr), .start_cnt_i(job_cnt),
        .fifo_empty_i(fifo_empty), .fifo_head_i(fifo_head), .fifo_pop_o(fifo_pop),
        .awvalid_o(m_awvalid), .awready_i(m_awready), .awaddr_o(m_awaddr),
        .wvalid_o(m_wvalid), .wready_i(m_wready), .wdata_o(m_wdata), .wlast_o(m_wlast),
        .bvalid_i(m_bvalid), .busy_o(busy)
    );

    assign m_awid    = '0;
    assign m_wid     = '0;
    assign m_awlen   = 8'(BURST_LEN - 1);
    assign m_awsize  = 3'(SIZE_CODE);
    assign m_awburst = AXI_BURST_INCR;
    assign m_wstrb   = '1;
    assign m_bready  = 1'b1;

endmodule

// File: rtl/strm_burst_wr_chk.sv
module strm_burst_wr_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int STEP = BURST_LEN * (DATA_W / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              fifo_full,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_wlast,
    input logic              busy,
    input logic              job_start
);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && fifo_full));

    // R4
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R4
    aw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && m_awready) |=> (!m_awvalid || (m_awaddr == $past(m_awaddr) + ADDR_W'(STEP))));

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> !busy);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !m_awvalid);

endmodule

bind strm_burst_wr strm_burst_wr_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .fifo_full(fifo_full),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
    .busy(busy), .job_start(job_start)
);

// File: tb/strm_burst_wr_tb.sv
`timescale 1ns/1ps
module strm_burst_wr_tb;

    localparam int NV = 6;
    // {address, count, stall divider}
    localparam logic [51:0] VEC [NV] = '{
        {32'h0000_1000, 16'd8,  4'd0},
        {32'h0000_2000, 16'd5,  4'd0},
        {32'h0000_3000, 16'd1,  4'd3},
        {32'h0000_4000, 16'd13, 4'd2},
        {32'h0000_FFF0, 16'd16, 4'd4},
        {32'h0000_8000, 16'd40, 4'd5}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_wr = 0, cfg_sel = 0;
    logic [31:0] cfg_data = '0;
    logic busy, s_valid, s_ready;
    logic [31:0] s_data;
    logic [3:0] m_awid, m_wid;
    logic [31:0] m_awaddr, m_wdata;
    logic [7:0] m_awlen;
    logic [2:0] m_awsize;
    logic [1:0] m_awburst;
    logic m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [3:0] m_wstrb;

    always #4 clk = ~clk;

    strm_burst_wr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .busy(busy), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wid(m_wid), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] src [128];
    int src_n = 0, stall_div = 0, exp_nb = 0;
    bit aw_en = 1, w_hold = 0, clr_tog = 0;
    // written only by the slave/stream process
    bit clr_seen = 0, saw_stop = 0;
    int cyc = 0, src_idx = 0, aw_n = 0, w_n = 0, wl_n = 0, b_iss = 0, b_got = 0;
    int busy_err = 0, attr_bad = 0, id_bad = 0, strb_bad = 0;
    logic [2:0] rdy_pipe = '0;
    logic [31:0] aw_addr_r [128];
    logic [31:0] w_data_r [128];
    logic w_last_r [128];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            s_valid = 0; s_data = '0; m_awready = 0; m_wready = 0; m_bvalid = 0;
            rdy_pipe = '0;
        end else begin
            cyc++;
            if (clr_tog != clr_seen) begin
                clr_seen = clr_tog;
                aw_n = 0; w_n = 0; wl_n = 0; b_iss = 0; b_got = 0; src_idx = 0;
                busy_err = 0; attr_bad = 0; id_bad = 0; strb_bad = 0; saw_stop = 0;
                s_valid = 0;
            end
            if (s_valid) src_idx++;          // taken at the last edge regardless of ready
            rdy_pipe = {rdy_pipe[1:0], s_ready};
            if (!s_ready) saw_stop = 1;
            s_valid = (src_idx < src_n) && rdy_pipe[2];
            s_data  = s_valid ? src[src_idx] : '0;
            if (m_bvalid) begin
                b_got++;
                if (busy != (b_got < exp_nb)) busy_err++;   // R9
                if (!m_bready) busy_err++;
            end
            m_bvalid = (b_iss < aw_n) && (b_iss < wl_n);
            if (m_bvalid) b_iss++;
            m_awready = aw_en;
            m_wready  = !w_hold && (stall_div == 0 || (cyc % stall_div) != 0);
            #1;
            if (m_awvalid && m_awready && aw_n < 128) begin
                aw_addr_r[aw_n] = m_awaddr;
                if (m_awlen != 8'd3 || m_awsize != 3'd2 || m_awburst != 2'b01) attr_bad++;
                if (m_awid != 0) id_bad++;
                aw_n++;
            end
            if (m_wvalid && m_wready && w_n < 128) begin
                w_data_r[w_n] = m_wdata;
                w_last_r[w_n] = m_wlast;
                if (m_wid != 0) id_bad++;
                if (m_wstrb != 4'hF) strb_bad++;
                if (m_wlast) wl_n++;
                w_n++;
            end
        end
    end

    function automatic logic [31:0] word(input int tag, input int i);
        return 32'hC0DE_0000 + 32'(tag << 12) + 32'(i);
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        cfg_wr = 1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_wr = 0; cfg_sel = 0;
    endtask

    task automatic prep(input int cnt, input int stall, input int tag);
        src_n = 0;
        for (int i = 0; i < cnt; i++) src[i] = word(tag, i);
        stall_div = stall;
        exp_nb = (cnt + 3) / 4;
        clr_tog = !clr_tog;
        repeat (2) @(negedge clk);
        src_n = cnt;
    endtask

    task automatic start_job(input logic [31:0] addr, input int cnt, input int stall, input int tag);
        prep(cnt, stall, tag);
        cfg_write(1, 32'h0);
        cfg_write(0, addr);
        cfg_write(0, 32'(cnt));
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!busy && t < 20) begin @(negedge clk); t++; end
        t = 0;
        while (busy && t < 6000) begin @(negedge clk); t++; end
        check(!busy, req, "transfer completes", busy, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_job(input logic [31:0] addr, input int cnt, input int tag);
        int nb = (cnt + 3) / 4;
        int abad = 0, dbad = 0, pbad = 0, lbad = 0;
        check(aw_n == nb, "R4", "burst count", aw_n, nb);
        for (int k = 0; k < aw_n; k++)
            if (aw_addr_r[k] != addr + 32'(k * 16)) abad++;
        check(abad == 0 && attr_bad == 0, "R4", "burst address and attributes", abad + attr_bad, 0);
        check(id_bad == 0, "R5", "zero IDs", id_bad, 0);
        check(w_n == nb * 4, "R6", "beat count", w_n, nb * 4);
        for (int i = 0; i < w_n; i++) begin
            if (i < cnt && w_data_r[i] != word(tag, i)) dbad++;
            if (i >= cnt && w_data_r[i] != 32'h0) pbad++;
            if (w_last_r[i] != (i % 4 == 3)) lbad++;
        end
        check(dbad == 0, "R6", "data order", dbad, 0);
        check(lbad == 0 && strb_bad == 0, "R6", "last and strobes", lbad + strb_bad, 0);
        if (cnt % 4 != 0) check(pbad == 0, "R7", "zero padding", pbad, 0);
        check(busy_err == 0 && b_got == nb, "R9", "busy against responses", busy_err, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10
        check(!busy && !m_awvalid && !m_wvalid, "R10", "idle after reset",
              {busy, m_awvalid, m_wvalid}, 0);
        check(s_ready && m_bready, "R10", "ready after reset", {s_ready, m_bready}, 3);

        for (int v = 0; v < NV; v++) begin
            start_job(VEC[v][51:20], int'(VEC[v][19:4]), int'(VEC[v][3:0]), v);
            wait_done("R9");
            check_job(VEC[v][51:20], int'(VEC[v][19:4]), v);
        end

        // R8: write channel stalled, buffer fills, upstream must stop
        w_hold = 1;
        start_job(32'h0001_0000, 32, 0, 10);
        repeat (60) @(negedge clk);
        check(!s_ready && saw_stop, "R8", "stop request under stall", s_ready, 0);
        check(src_idx < 32 && src_idx >= 12, "R8", "upstream paused", src_idx, 16);
        w_hold = 0;
        wait_done("R8");
        check_job(32'h0001_0000, 32, 10);
        check(s_ready, "R8", "ready returns when drained", s_ready, 1);

        // R2: zero count
        start_job(32'h0000_B000, 0, 0, 11);
        repeat (10) @(negedge clk);
        check(!busy && aw_n == 0 && w_n == 0, "R2", "zero count idle", aw_n + w_n + busy, 0);

        // R3: writes during a stalled transfer are ignored
        aw_en = 0; w_hold = 1;
        start_job(32'h0000_9000, 8, 0, 12);
        repeat (10) @(negedge clk);
        check(busy, "R3", "held transfer busy", busy, 1);
        cfg_write(1, 32'h0);
        cfg_write(0, 32'h0000_A000);
        cfg_write(0, 32'd4);
        repeat (5) @(negedge clk);
        aw_en = 1; w_hold = 0;
        wait_done("R3");
        check_job(32'h0000_9000, 8, 12);
        repeat (20) @(negedge clk);
        check(!busy && aw_n == 2, "R3", "no second transfer", aw_n, 2);

        // R1: writes without select while idle are ignored
        prep(0, 0, 13);
        cfg_write(0, 32'h0000_C000);
        cfg_write(0, 32'd4);
        repeat (10) @(negedge clk);
        check(!busy && aw_n == 0, "R1", "unselected writes ignored", aw_n, 0);

        // R1: select in mid sequence restarts at the address step
        prep(4, 0, 14);
        cfg_write(1, 32'h0);
        cfg_write(0, 32'h0000_D000);
        cfg_write(1, 32'h0);
        cfg_write(0, 32'h0000_E000);
        cfg_write(0, 32'd4);
        wait_done("R1");
        check(aw_n == 1 && aw_addr_r[0] == 32'h0000_E000, "R1", "reselected address",
              aw_addr_r[0], 32'h0000_E000);
        check_job(32'h0000_E000, 4, 14);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule